// File: doc/BRIEF.md
# Overlapping Register Window File

This block is the integer register file of a RISC core in which every procedure activation gets its own window of registers. Logical register numbers 0 to 31 fall into four groups of eight. Numbers 0 to 7 are globals, and all windows share them. Numbers 8 to 15 are incoming parameters. Numbers 16 to 23 are private locals. Numbers 24 to 31 are outgoing temporaries.

A call moves the current window forward by one and a return moves it back. Window w's temporaries are the same flops as window w+1's parameters, so arguments and results cross a call boundary without being copied.

Two pointers run modulo the window count: the current window and a saved-window marker. The marker names a reserved window that no activation may enter. That limits the file to N-1 resident activations. A call that would enter the marked window raises an overflow trap, and a return that would enter it raises an underflow trap. In both cases the pointer stays where it was.

A trap handler uses the save/restore port to move one window between the file and memory. On overflow it reads the parameters and locals of the oldest resident window, then advances the marker. On underflow it writes them back into the marked window, then retreats the marker. The core then retries the call or return.

Top module: `regwin_file`

## Requirements
- R1: Logical registers 1 to 7 are global: the value written there reads back unchanged from every window, before and after calls and returns.
- R2: Logical register 0 always reads as zero on both read ports, and a write to it has no effect.
- R3: Logical registers 24+k of window w and 8+k of window w+1 (mod N) are one storage element: a value written through either name reads back through the other after a call or a return.
- R4: Logical registers 16 to 23 are private to each window: the locals of a window keep their values across calls into deeper windows and the returns back.
- R5: Out of reset the current window is 0. A call advances it by one, unless the next window equals the saved-window marker. In that case `ovf_trap` is high for the one cycle after the call strobe and the current window is unchanged.
- R6: A return (with no call in the same cycle) moves the current window back by one, unless the previous window equals the marker. In that case `unf_trap` is high for the one cycle after the strobe and the current window is unchanged.
- R7: Reset sets the marker to N-1 with both traps low, so a return issued straight out of reset raises `unf_trap`.
- R8: `spill_rdata` shows the window just above the marker. `sf_idx` 0 to 7 selects its parameters and 8 to 15 its locals. A `spill_done` strobe advances the marker by one, but is ignored when the advanced marker would equal the next-cycle current window.
- R9: With `fill_we` high, `fill_wdata` is written into the marked window at `sf_idx` (same index coding as R8). A `fill_done` strobe moves the marker back by one, but is ignored when the moved marker would equal the next-cycle current window.
- R10: When a port reads the physical register being written in the same cycle, it returns the new write data.
- R11: When call and return strobes arrive together, the call is performed and the return is ignored.
- R12: The current window never equals the saved-window marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ra_a | input | 5 | Logical register number, read port A |
| rdata_a | output | 32 | Read data, port A (combinational) |
| ra_b | input | 5 | Logical register number, read port B |
| rdata_b | output | 32 | Read data, port B (combinational) |
| we | input | 1 | Core write enable |
| wa | input | 5 | Logical register number to write |
| wdata | input | 32 | Core write data |
| call_en | input | 1 | Procedure call strobe |
| ret_en | input | 1 | Procedure return strobe |
| ovf_trap | output | 1 | Window overflow trap, one-cycle pulse |
| unf_trap | output | 1 | Window underflow trap, one-cycle pulse |
| sf_idx | input | 4 | Save/restore index: 0-7 parameters, 8-15 locals |
| spill_rdata | output | 32 | Data of the window to be saved |
| spill_done | input | 1 | Strobe: one window saved, advance the marker |
| fill_we | input | 1 | Restore write enable into the marked window |
| fill_wdata | input | 32 | Restore write data |
| fill_done | input | 1 | Strobe: one window restored, retreat the marker |

## Verification
Some properties are checked by assertions on every cycle:
- The current window and the marker never coincide.
- A call or a return moves the current window by exactly one, or the matching trap fires and the pointer holds.
- The two traps are never high together.
- Register 0 reads as zero.
- A same-cycle write reaches the reads that name it.

Other behaviour only the bench scenarios can show, because it depends on data stored earlier:
- Values cross windows through the overlap.
- Locals survive a climb through all windows.
- An overflow is followed by a save, a retried call, an underflow, a restore and a retried return.
- The guards on the marker strobes work.
- A call wins over a simultaneous return.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  // Group of a logical register number, taken from its two upper bits.
  typedef enum logic [1:0] {
    GRP_GLB = 2'd0,
    GRP_PAR = 2'd1,
    GRP_LOC = 2'd2,
    GRP_TMP = 2'd3
  } grp_e;

endpackage

// File: rtl/regwin_xlate.sv
// Maps a logical register number within a window to a physical index.
// Physical layout: globals first, then per window eight parameters
// followed by eight locals. Temporaries alias the next window's parameters.
module regwin_xlate
  import regwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int NGRP = 8,
  localparam int WW = $clog2(NWIN),
  localparam int GW = $clog2(NGRP),
  localparam int LRW = GW + 2,
  localparam int NPHYS = NGRP + 2 * NGRP * NWIN,
  localparam int PW = $clog2(NPHYS)
) (
  input  logic [WW-1:0]  win_i,
  input  logic [LRW-1:0] lreg_i,
  output logic [PW-1:0]  preg_o
);

  localparam int WSTRIDE = 2 * NGRP;

  grp_e          grp;
  logic [GW-1:0] off;
  logic [WW-1:0] win_nxt;
  logic [PW-1:0] base_cur;
  logic [PW-1:0] base_nxt;

  assign grp      = grp_e'(lreg_i[LRW-1:GW]);
  assign off      = lreg_i[GW-1:0];
  assign win_nxt  = win_i + WW'(1);
  assign base_cur = PW'(NGRP) + PW'(win_i) * PW'(WSTRIDE);
  assign base_nxt = PW'(NGRP) + PW'(win_nxt) * PW'(WSTRIDE);

  always_comb begin
    case (grp)
      GRP_GLB: preg_o = PW'(off);
      GRP_PAR: preg_o = base_cur + PW'(off);
      GRP_LOC: preg_o = base_cur + PW'(NGRP) + PW'(off);
      default: preg_o = base_nxt + PW'(off);
    endcase
  end

endmodule

// File: rtl/regwin_ptr_ctl.sv
// Current-window and saved-window pointers with trap detection.
module regwin_ptr_ctl #(
  parameter int NWIN = 8,
  localparam int WW = $clog2(NWIN)
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic          spill_adv_i,
  input  logic          fill_adv_i,
  output logic [WW-1:0] cwp_o,
  output logic [WW-1:0] swp_o,
  output logic          ovf_o,
  output logic          unf_o
);

  logic [WW-1:0] cwp_q, cwp_d;
  logic [WW-1:0] swp_q, swp_d;
  logic          ovf_q, ovf_d;
  logic          unf_q, unf_d;
  logic [WW-1:0] cwp_inc, cwp_dec, swp_inc, swp_dec;

  assign cwp_inc = cwp_q + WW'(1);
  assign cwp_dec = cwp_q - WW'(1);
  assign swp_inc = swp_q + WW'(1);
  assign swp_dec = swp_q - WW'(1);

  // Next-state logic
  always_comb begin
    ovf_d = call_i && (cwp_inc == swp_q);
    unf_d = ret_i && !call_i && (cwp_dec == swp_q);
    cwp_d = cwp_q;
    if (call_i) begin
      if (!ovf_d) cwp_d = cwp_inc;
    end else if (ret_i && !unf_d) begin
      cwp_d = cwp_dec;
    end
    swp_d = swp_q;
    if (spill_adv_i) begin
      if (swp_inc != cwp_d) swp_d = swp_inc;
    end else if (fill_adv_i) begin
      if (swp_dec != cwp_d) swp_d = swp_dec;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cwp_q <= '0;
      swp_q <= WW'(NWIN - 1);
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      cwp_q <= cwp_d;
      swp_q <= swp_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  assign cwp_o = cwp_q;
  assign swp_o = swp_q;
  assign ovf_o = ovf_q;
  assign unf_o = unf_q;

  // R5 R11
  call_step_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    call_i |=> (ovf_q || cwp_q == WW'($past(cwp_q) + WW'(1))));

  // R6
  ret_step_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ret_i && !call_i) |=> (unf_q || cwp_q == WW'($past(cwp_q) - WW'(1))));

  // R5
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ovf_q |-> $stable(cwp_q));

  // R6
  unf_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    unf_q |-> $stable(cwp_q));

  // R5 R6
  trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0({ovf_q, unf_q}));

  // R12
  win_sep_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    cwp_q != swp_q);

endmodule

// File: rtl/regwin_store.sv
// Flop array with a core write port, a restore write port and
// several combinational read ports with write-first bypass.
module regwin_store #(
  parameter int DW = 32,
  parameter int NPHYS = 136,
  parameter int NRD = 3,
  localparam int PW = $clog2(NPHYS)
) (
  input  logic          clk,
  input  logic          we_a_i,
  input  logic [PW-1:0] wa_a_i,
  input  logic [DW-1:0] wd_a_i,
  input  logic          we_b_i,
  input  logic [PW-1:0] wa_b_i,
  input  logic [DW-1:0] wd_b_i,
  input  logic [PW-1:0] ra_i [NRD],
  output logic [DW-1:0] rd_o [NRD]
);

  logic [DW-1:0] mem_q [NPHYS];

  // Core port is applied last so it wins a collision.
  always_ff @(posedge clk) begin
    if (we_b_i) mem_q[wa_b_i] <= wd_b_i;
    if (we_a_i) mem_q[wa_a_i] <= wd_a_i;
  end

  always_comb begin
    for (int r = 0; r < NRD; r++) begin
      if (we_a_i && (wa_a_i == ra_i[r]))      rd_o[r] = wd_a_i;
      else if (we_b_i && (wa_b_i == ra_i[r])) rd_o[r] = wd_b_i;
      else                                    rd_o[r] = mem_q[ra_i[r]];
    end
  end

endmodule

// File: rtl/regwin_file.sv
module regwin_file #(
  parameter int DW = 32,
  parameter int NWIN = 8,
  parameter int NGRP = 8,
  localparam int WW = $clog2(NWIN),
  localparam int GW = $clog2(NGRP),
  localparam int LRW = GW + 2,
  localparam int SIW = GW + 1,
  localparam int NPHYS = NGRP + 2 * NGRP * NWIN,
  localparam int PW = $clog2(NPHYS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [LRW-1:0] ra_a,
  output logic [DW-1:0]  rdata_a,
  input  logic [LRW-1:0] ra_b,
  output logic [DW-1:0]  rdata_b,
  input  logic           we,
  input  logic [LRW-1:0] wa,
  input  logic [DW-1:0]  wdata,
  input  logic           call_en,
  input  logic           ret_en,
  output logic           ovf_trap,
  output logic           unf_trap,
  input  logic [SIW-1:0] sf_idx,
  output logic [DW-1:0]  spill_rdata,
  input  logic           spill_done,
  input  logic           fill_we,
  input  logic [DW-1:0]  fill_wdata,
  input  logic           fill_done
);

  localparam int NXL = 5;  // read A, read B, write, save, restore
  localparam int NRD = 3;  // read A, read B, save

  // Reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // Window pointers
  logic [WW-1:0] cwp, swp;

  regwin_ptr_ctl #(.NWIN(NWIN)) u_ptr (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .call_i      (call_en),
    .ret_i       (ret_en),
    .spill_adv_i (spill_done),
    .fill_adv_i  (fill_done),
    .cwp_o       (cwp),
    .swp_o       (swp),
    .ovf_o       (ovf_trap),
    .unf_o       (unf_trap)
  );

  // Address translation
  logic [WW-1:0]  x_win  [NXL];
  logic [LRW-1:0] x_lreg [NXL];
  logic [PW-1:0]  x_preg [NXL];
  logic [LRW-1:0] sf_lreg;

  // Save/restore index: upper bit picks locals, else parameters.
  assign sf_lreg = {sf_idx[GW], ~sf_idx[GW], sf_idx[GW-1:0]};

  assign x_win[0]  = cwp;
  assign x_lreg[0] = ra_a;
  assign x_win[1]  = cwp;
  assign x_lreg[1] = ra_b;
  assign x_win[2]  = cwp;
  assign x_lreg[2] = wa;
  assign x_win[3]  = swp + WW'(1);
  assign x_lreg[3] = sf_lreg;
  assign x_win[4]  = swp;
  assign x_lreg[4] = sf_lreg;

  for (genvar i = 0; i < NXL; i++) begin : g_xl
    regwin_xlate #(.NWIN(NWIN), .NGRP(NGRP)) u_xl (
      .win_i  (x_win[i]),
      .lreg_i (x_lreg[i]),
      .preg_o (x_preg[i])
    );
  end

  // Storage
  logic [PW-1:0] st_ra [NRD];
  logic [DW-1:0] st_rd [NRD];
  logic          core_we;

  assign core_we  = we && (wa != '0);
  assign st_ra[0] = x_preg[0];
  assign st_ra[1] = x_preg[1];
  assign st_ra[2] = x_preg[3];

  regwin_store #(.DW(DW), .NPHYS(NPHYS), .NRD(NRD)) u_store (
    .clk    (clk),
    .we_a_i (core_we),
    .wa_a_i (x_preg[2]),
    .wd_a_i (wdata),
    .we_b_i (fill_we),
    .wa_b_i (x_preg[4]),
    .wd_b_i (fill_wdata),
    .ra_i   (st_ra),
    .rd_o   (st_rd)
  );

  assign rdata_a     = (ra_a == '0) ? '0 : st_rd[0];
  assign rdata_b     = (ra_b == '0) ? '0 : st_rd[1];
  assign spill_rdata = st_rd[2];

  // R2
  zero_rd_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (ra_b == '0) |-> (rdata_b == '0));

  // R10
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (we && wa != '0 && ra_b == wa) |-> (rdata_b == wdata));

endmodule

// File: tb/regwin_file_test.sv
`timescale 1ns/1ps
module regwin_file_test;

  logic        clk;
  logic        rst_n;
  logic [4:0]  ra_a, ra_b, wa;
  logic [31:0] rdata_a, rdata_b, wdata;
  logic        we, call_en, ret_en;
  logic        ovf_trap, unf_trap;
  logic [3:0]  sf_idx;
  logic [31:0] spill_rdata, fill_wdata;
  logic        spill_done, fill_we, fill_done;

  regwin_file uut (
    .clk(clk), .rst_n(rst_n),
    .ra_a(ra_a), .rdata_a(rdata_a), .ra_b(ra_b), .rdata_b(rdata_b),
    .we(we), .wa(wa), .wdata(wdata),
    .call_en(call_en), .ret_en(ret_en),
    .ovf_trap(ovf_trap), .unf_trap(unf_trap),
    .sf_idx(sf_idx), .spill_rdata(spill_rdata), .spill_done(spill_done),
    .fill_we(fill_we), .fill_wdata(fill_wdata), .fill_done(fill_done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Scoreboard: kind 0 rdata_a, 1 rdata_b, 2 ovf_trap, 3 unf_trap, 4 spill_rdata
  typedef struct {
    int          cyc;
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int    cyc_cnt = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  function automatic void push(int c, int k, logic [31:0] e, string t);
    item_t it;
    it.cyc = c; it.kind = k; it.exp = e; it.tag = t;
    sb_q.push_back(it);
  endfunction

  // Monitor
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].cyc <= cyc_cnt) begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        0: act = rdata_a;
        1: act = rdata_b;
        2: act = {31'd0, ovf_trap};
        3: act = {31'd0, unf_trap};
        default: act = spill_rdata;
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic nxt();
    @(posedge clk);
    #1;
    we = 0; call_en = 0; ret_en = 0;
    spill_done = 0; fill_we = 0; fill_done = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    we = 1; wa = a; wdata = d; nxt();
  endtask

  task automatic rd_a(input logic [4:0] a, input logic [31:0] e, input string t);
    ra_a = a; push(cyc_cnt, 0, e, t); nxt();
  endtask

  task automatic wr_rd(input logic [4:0] a, input logic [31:0] d,
                       input logic [31:0] e, input string t);
    we = 1; wa = a; wdata = d; ra_b = a; push(cyc_cnt, 1, e, t); nxt();
  endtask

  task automatic do_call(input bit exp_ovf, input string t);
    call_en = 1; push(cyc_cnt + 1, 2, {31'd0, exp_ovf}, t); nxt();
  endtask

  task automatic do_ret(input bit exp_unf, input string t);
    ret_en = 1; push(cyc_cnt + 1, 3, {31'd0, exp_unf}, t); nxt();
  endtask

  task automatic spill_chk(input logic [3:0] i, input logic [31:0] e, input string t);
    sf_idx = i; push(cyc_cnt, 4, e, t); nxt();
  endtask

  task automatic fill(input logic [3:0] i, input logic [31:0] d);
    fill_we = 1; sf_idx = i; fill_wdata = d; nxt();
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  // Driver
  initial begin
    rst_n = 0; ra_a = 0; ra_b = 0; wa = 0; wdata = 0;
    we = 0; call_en = 0; ret_en = 0; sf_idx = 0;
    fill_we = 0; fill_wdata = 0; spill_done = 0; fill_done = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) nxt();

    // R7: traps low out of reset, return from window 0 underflows
    push(cyc_cnt, 2, 32'd0, "R7");
    push(cyc_cnt, 3, 32'd0, "R7");
    do_ret(1, "R7");

    // R2, R1
    wr(5'd0, 32'hDEAD);
    rd_a(5'd0, 32'd0, "R2");
    wr(5'd1, 32'h11);
    rd_a(5'd1, 32'h11, "R1");

    // Window 0 contents
    wr(5'd8, 32'hA0);
    wr(5'd16, 32'hB0);
    wr(5'd24, 32'hC0);
    rd_a(5'd16, 32'hB0, "R4");

    // R10 bypass, and R2 on the bypass path
    wr_rd(5'd9, 32'h5A5A, 32'h5A5A, "R10");
    wr_rd(5'd0, 32'h7777, 32'd0, "R2");

    // R3 overlap across a call
    do_call(0, "R5");
    rd_a(5'd8, 32'hC0, "R3");
    rd_a(5'd1, 32'h11, "R1");
    wr(5'd8, 32'hD1);
    wr(5'd16, 32'h101);
    do_ret(0, "R6");
    rd_a(5'd24, 32'hD1, "R3");
    rd_a(5'd16, 32'hB0, "R4");
    rd_a(5'd1, 32'h11, "R1");

    // Climb to window 6
    wr(5'd16, 32'h100);
    for (int w = 1; w <= 6; w++) begin
      do_call(0, "R5");
      wr(5'd16, 32'h100 + w);
    end
    // R5 overflow: pointer held
    do_call(1, "R5");
    rd_a(5'd16, 32'h106, "R5");

    // R8 save the oldest window (window 0)
    spill_chk(4'd8, 32'h100, "R8");
    spill_chk(4'd0, 32'hA0, "R8");
    spill_done = 1; nxt();
    do_call(0, "R8");
    wr(5'd16, 32'h107);
    wr(5'd24, 32'hE7);

    // R9 R12: restore strobe ignored when the file is full
    fill_done = 1; nxt();
    do_call(1, "R9");

    // Descend to window 1
    do_ret(0, "R6");
    rd_a(5'd16, 32'h106, "R4");
    for (int w = 6; w >= 2; w--) do_ret(0, "R6");
    rd_a(5'd16, 32'h101, "R4");
    // R6 underflow: window 0 is not resident
    do_ret(1, "R6");
    rd_a(5'd16, 32'h101, "R6");

    // R9 restore window 0 then retry the return
    fill(4'd8, 32'h200);
    fill(4'd0, 32'h2A0);
    fill_done = 1; nxt();
    do_ret(0, "R9");
    rd_a(5'd16, 32'h200, "R9");
    rd_a(5'd8, 32'h2A0, "R9");
    rd_a(5'd1, 32'h11, "R1");

    // R8 R12: save strobe ignored when it would reach the current window
    spill_done = 1; nxt();
    do_ret(1, "R8");

    // R11 call wins over return
    call_en = 1; ret_en = 1;
    push(cyc_cnt + 1, 3, 32'd0, "R11");
    push(cyc_cnt + 1, 2, 32'd0, "R11");
    nxt();
    rd_a(5'd16, 32'h101, "R11");
    do_ret(0, "R11");
    rd_a(5'd16, 32'h200, "R11");

    repeat (3) nxt();
    done = 1'b1;
    finish_run();
  end

endmodule